// File: doc/BRIEF.md
# Bus Target with Burst Register Window

This block is the slave end of a synchronous, PCI-style shared bus. One 32-bit path carries an address first and then data. A 4-bit field carries the command while the address is on the path, and active-low byte-lane enables while data is on it. Four active-low control lines frame the exchange:

- `frame_n` is driven by the initiator and spans the transaction.
- `irdy_n` is the initiator's ready.
- `trdy_n` is the target's ready.
- `devsel_n` is the target's claim.

The target owns a 64-byte, word-aligned window and keeps sixteen 32-bit words in flops. It claims memory-read and memory-write transactions whose address falls inside that window. It then serves a burst of data phases until the initiator signals the last one.

Each data phase is a valid/ready exchange. On a write, `irdy_n` low means the word on the path is valid and `trdy_n` low means the target takes it. On a read the roles are swapped. A word moves only at a rising edge where both are low, and either side can stall by holding its line high. The target never stalls a write phase. It stalls a read only in the single turnaround cycle that follows the address. All inputs are sampled on the rising edge. Every driven output changes on the falling edge.

Top module: `pci_lite_target`

## Requirements
- R1: A transaction is claimed when, at the first rising edge with `frame_n` low (the address phase), `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write) and `ad_in[31:6]` equals `BASE_ADDR[31:6]`. For a claimed transaction, `devsel_n` goes low at the following falling edge and stays low while the transaction runs; `trdy_n` is never low while `devsel_n` is high.
- R2: Any other command, or an address outside the window, is ignored. `devsel_n` and `trdy_n` stay high, `ad_oe` stays low, and no stored word changes.
- R3: A write data phase completes at a rising edge where `irdy_n` and `trdy_n` are both low. Byte lane b (`ad_in[8b+7:8b]`) of the current word is stored only when `cbe_n[b]` is 0. On a write, `trdy_n` goes low together with `devsel_n`, so the first data phase can complete at the edge right after the address phase.
- R4: On a read, the first rising edge after the address phase is a turnaround: `trdy_n` is high and `ad_oe` is low there. The first read word can complete no earlier than the second rising edge after the address phase.
- R5: During a read data phase with `trdy_n` low, `ad_oe` is high and `ad_out` holds the stored word at the current index. `ad_oe` is never high unless `trdy_n` is low.
- R6: The current word index starts at `ad_in[5:2]` from the address phase. It advances by one after each completed data phase and wraps from 15 to 0 within the window.
- R7: While `trdy_n` is low and `irdy_n` is high, no transfer occurs, the index holds, and `trdy_n` stays low at the next edge.
- R8: A data phase completed while `frame_n` is high is the last one. At the next falling edge `devsel_n` and `trdy_n` return high and `ad_oe` goes low.
- R9: After reset, `devsel_n` and `trdy_n` are high, `ad_oe` is low and all stored words are zero. The outputs change only at falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; inputs sampled on the rising edge, outputs updated on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction span from the initiator, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_in | input | 32 | Address/data path as seen by the target |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_out | output | 32 | Read data the target drives onto the path |
| ad_oe | output | 1 | High while the target drives `ad_out` onto the path |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Target claim, active low |

## Verification
The properties assume a well-behaved initiator. It raises `frame_n` only in a cycle where `irdy_n` is low, and it leaves at least one idle edge with `frame_n` high between transactions. Because of this, a falling `frame_n` always marks an address phase, and the command is on `cbe_n` in exactly that cycle. The bench's driver tasks hold to these rules. They change inputs just after a rising edge and always mark the last phase by raising `frame_n` together with a low `irdy_n`. Ignored transactions are still driven with full, legal framing, so a wrong claim would show up as a real transfer.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_XFER = 2'd2
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pcit_decode.sv
module pcit_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0400,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic [31:2]                word_addr,
  input  logic [3:0]                 cmd,
  output logic                       hit,
  output logic                       is_rd,
  output logic [$clog2(WIN_BYTES)-3:0] start_idx
);
  import pcit_pkg::*;
  localparam int unsigned LOG_WIN = $clog2(WIN_BYTES);

  logic in_window;
  logic cmd_ok;

  always_comb begin
    in_window = (word_addr[31:LOG_WIN] == BASE_ADDR[31:LOG_WIN]);
    cmd_ok    = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    hit       = in_window && cmd_ok;
    is_rd     = (cmd == CMD_MEM_RD);
    start_idx = word_addr[LOG_WIN-1:2];
  end
endmodule

// File: rtl/pcit_regfile.sv
module pcit_regfile #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [DW/8-1:0]          wbe_n,
  input  logic [$clog2(WORDS)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(WORDS)-1:0] ridx,
  output logic [DW-1:0]            rdata
);
  localparam int unsigned IDXW  = $clog2(WORDS);
  localparam int unsigned LANES = DW / 8;

  logic [DW-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    logic          sel;
    assign sel = we && (widx == IDXW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel) begin
        for (int b = 0; b < LANES; b++) begin
          if (!wbe_n[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end

    assign words[w] = word_q;
  end

  assign rdata = words[ridx];
endmodule

// File: rtl/pcit_ctrl.sv
module pcit_ctrl #(
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            hit,
  input  logic            is_rd,
  input  logic [IDXW-1:0] start_idx,
  output logic            claim,
  output logic            ready,
  output logic            rd_mode,
  output logic            wr_en,
  output logic [IDXW-1:0] cur_idx
);
  import pcit_pkg::*;

  tgt_state_e state_q, state_d;
  logic       frame_q;
  logic       addr_phase;
  logic       xfer;
  logic       last;

  always_comb begin
    addr_phase = frame_q && !frame_n && (state_q == ST_IDLE);
    xfer       = (state_q == ST_XFER) && !irdy_n;
    last       = xfer && frame_n;
    wr_en      = xfer && !rd_mode;
    claim      = (state_q != ST_IDLE);
    ready      = (state_q == ST_XFER);

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (addr_phase && hit) state_d = is_rd ? ST_TURN : ST_XFER;
      ST_TURN: state_d = ST_XFER;
      ST_XFER: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
      rd_mode <= 1'b0;
      cur_idx <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_n;
      if (addr_phase && hit) begin
        rd_mode <= is_rd;
        cur_idx <= start_idx;
      end else if (xfer) begin
        cur_idx <= cur_idx + IDXW'(1);
      end
    end
  end
endmodule

// File: rtl/pci_lite_target.sv
module pci_lite_target #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0400,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic        irdy_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n,
  output logic        devsel_n
);
  localparam int unsigned WORDS = WIN_BYTES / 4;
  localparam int unsigned IDXW  = $clog2(WORDS);

  logic            hit;
  logic            is_rd;
  logic [IDXW-1:0] start_idx;
  logic            claim;
  logic            ready;
  logic            rd_mode;
  logic            wr_en;
  logic [IDXW-1:0] cur_idx;
  logic [31:0]     rdata;

  pcit_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) u_decode (
    .word_addr (ad_in[31:2]),
    .cmd       (cbe_n),
    .hit       (hit),
    .is_rd     (is_rd),
    .start_idx (start_idx)
  );

  pcit_ctrl #(.IDXW(IDXW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .hit       (hit),
    .is_rd     (is_rd),
    .start_idx (start_idx),
    .claim     (claim),
    .ready     (ready),
    .rd_mode   (rd_mode),
    .wr_en     (wr_en),
    .cur_idx   (cur_idx)
  );

  pcit_regfile #(.WORDS(WORDS), .DW(32)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wbe_n (cbe_n),
    .widx  (cur_idx),
    .wdata (ad_in),
    .ridx  (cur_idx),
    .rdata (rdata)
  );

  // Output stage: state settles at the rising edge, pins move at the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
    end else begin
      devsel_n <= !claim;
      trdy_n   <= !ready;
      ad_oe    <= ready && rd_mode;
      ad_out   <= (ready && rd_mode) ? rdata : '0;
    end
  end
endmodule

// File: rtl/pci_lite_target_chk.sv
module pci_lite_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic [3:0] cbe_n,
  input logic       trdy_n,
  input logic       devsel_n,
  input logic       ad_oe
);
  AST_READY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n); // R1

  AST_FOREIGN_CMD_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && cbe_n != 4'b0110 && cbe_n != 4'b0111) |=> devsel_n); // R2

  AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && cbe_n == 4'b0110) |=> (trdy_n && !ad_oe)); // R4

  AST_DRIVE_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n); // R5

  AST_WAIT_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> !trdy_n); // R7

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe)); // R8
endmodule

bind pci_lite_target pci_lite_target_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .irdy_n   (irdy_n),
  .cbe_n    (cbe_n),
  .trdy_n   (trdy_n),
  .devsel_n (devsel_n),
  .ad_oe    (ad_oe)
);

// File: tb/pci_lite_target_tb_top.sv
`timescale 1ns/1ps
module pci_lite_target_tb_top;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic        trdy_n;
  logic        devsel_n;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [16];
  logic [31:0] expq [$];
  logic [31:0] wd [8];
  logic [3:0]  wb [8];

  always #4 clk = ~clk;

  pci_lite_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .cbe_n(cbe_n), .ad_in(ad_in),
    .irdy_n(irdy_n), .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .devsel_n(devsel_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected read word at every completed read phase (R5, R6).
  always @(posedge clk) begin
    if (rst_n && !trdy_n && !irdy_n && ad_oe) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected read word", ad_out, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(ad_out == e, "R5/R6 read data", ad_out, e);
      end
    end
  end

  task automatic go_idle();
    #1 frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
  endtask

  task automatic do_write(input logic [31:0] addr, input int n, input int wait_at, input bit probe);
    int idx;
    int edges;
    idx = int'(addr[5:2]);
    @(posedge clk);
    #1 frame_n = 1'b0; ad_in = addr; cbe_n = 4'b0111; irdy_n = 1'b1;
    @(posedge clk);
    if (probe) begin
      #1 chk(devsel_n == 1'b1, "R9 devsel held until falling edge", {31'b0, devsel_n}, 32'h1);
      @(negedge clk);
      #1 chk(devsel_n == 1'b0, "R1 claim at falling edge", {31'b0, devsel_n}, 32'h0);
    end
    for (int k = 0; k < n; k++) begin
      if (k == wait_at) begin
        #1 irdy_n = 1'b1;
        @(posedge clk);
        chk(trdy_n == 1'b0, "R7 trdy held in write wait", {31'b0, trdy_n}, 32'h0);
      end
      #1 ad_in = wd[k]; cbe_n = wb[k]; irdy_n = 1'b0; frame_n = (k == n - 1);
      edges = 0;
      do begin @(posedge clk); edges++; end while (trdy_n);
      if (k == 0) chk(edges == 1, "R3 write phase without stall", edges, 1);
      for (int b = 0; b < 4; b++)
        if (!wb[k][b]) model[idx][8*b +: 8] = wd[k][8*b +: 8];
      idx = (idx + 1) % 16;
    end
    go_idle();
    @(negedge clk);
    #1 chk(devsel_n && trdy_n && !ad_oe, "R8 release after last write",
           {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
  endtask

  task automatic do_read(input logic [31:0] addr, input int n, input int wait_at);
    int idx;
    int edges;
    idx = int'(addr[5:2]);
    for (int k = 0; k < n; k++) expq.push_back(model[(idx + k) % 16]);
    @(posedge clk);
    #1 frame_n = 1'b0; ad_in = addr; cbe_n = 4'b0110; irdy_n = 1'b1;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == wait_at) begin
        #1 irdy_n = 1'b1; ad_in = '0;
        @(posedge clk);
        if (k > 0) chk(trdy_n == 1'b0, "R7 trdy held in read wait", {31'b0, trdy_n}, 32'h0);
      end
      #1 cbe_n = 4'h0; ad_in = '0; irdy_n = 1'b0; frame_n = (k == n - 1);
      edges = 0;
      do begin @(posedge clk); edges++; end while (trdy_n);
      if (k == 0 && wait_at != 0) chk(edges == 2, "R4 one turnaround edge", edges, 2);
    end
    go_idle();
    @(negedge clk);
    #1 chk(devsel_n && trdy_n && !ad_oe, "R8 release after last read",
           {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    chk(expq.size() == 0, "R5 all read words seen", expq.size(), 0);
  endtask

  task automatic do_ignored(input logic [31:0] addr, input logic [3:0] cmd);
    @(posedge clk);
    #1 frame_n = 1'b0; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1 ad_in = 32'hDEAD_0000 | k; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = (k == 2);
      @(negedge clk);
      #1 chk(devsel_n && trdy_n && !ad_oe, "R2 no claim",
             {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    end
    @(posedge clk);
    go_idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #1 chk(devsel_n && trdy_n && !ad_oe, "R9 reset outputs",
           {29'b0, devsel_n, trdy_n, ad_oe}, 32'h6);
    rst_n = 1'b1;
    @(posedge clk);
    do_read(BASE, 2, -1);                      // R9: cleared storage

    for (int i = 0; i < 8; i++) begin wd[i] = 32'h1111_1111 * (i + 1); wb[i] = 4'h0; end
    do_write(BASE, 4, -1, 1'b1);               // R1, R3
    do_read(BASE, 4, -1);                      // R4, R5, R6

    wd[0] = 32'hA5B6_C7D8; wb[0] = 4'b1010;    // lanes 0 and 2 only
    do_write(BASE + 32'd20, 1, -1, 1'b0);      // R3 byte enables
    do_read(BASE + 32'd20, 1, -1);

    for (int i = 0; i < 4; i++) begin wd[i] = 32'hC0DE_0000 + i; wb[i] = 4'h0; end
    do_write(BASE + 32'd56, 4, 2, 1'b0);       // R6 wrap, R7 wait
    do_read(BASE + 32'd56, 6, 1);              // R6, R7

    do_ignored(BASE, 4'b0010);                 // R2 wrong command
    do_ignored(BASE + 32'd64, 4'b0111);        // R2 above window
    do_ignored(BASE - 32'd4, 4'b0111);         // R2 below window
    do_read(BASE, 16, 3);                      // R2 storage untouched

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule